// File: doc/BRIEF.md
# Modulo Timer with Divider Prescaler

This block is an 8-bit up-counting timer/counter that reloads from a modulo register instead of wrapping to zero. Each time the counter steps past its all-ones value it takes the modulo value and raises a one-cycle overflow pulse. An interrupt controller turns that pulse into a timer request flag. The count advances on one of four sources: every active system-clock cycle, a divide-by-128 tap of a 15-stage prescaler, a divide-by-32768 tap of the same prescaler, or falling edges on an external pin.

The host side of the block sees only enable strobes. It loads the modulo register from two 4-bit halves and writes a 4-bit control word holding the run bit and the source select. A command strobe copies the modulo value into the counter, and another command strobe clears the prescaler. `sys_en_i` stands for the gated system clock. When it is low, as in stop mode, the prescaler and the system source freeze, but the external-edge source keeps counting.

Top module: `modulo_timer`

## Requirements
- R1: After reset the counter, the modulo register, the control register and the overflow output are all zero.
- R2: A modulo write loads `mod_hi_i` into bits 7:4 and `mod_lo_i` into bits 3:0, and the value is readable on `mod_o` after the next clock edge.
- R3: A control write stores bit 3 (run) and bits 1:0 (source select). Bit 2 is discarded and always reads 0 on `ctrl_o`.
- R4: With run=1 and select 00, the counter increments once per cycle in which `sys_en_i` is high, and it holds while `sys_en_i` is low.
- R5: With run=0, the counter holds its value whatever the source activity.
- R6: A count event at value 8'hFF loads the modulo value into the counter, and `ovf_o` is high for exactly the following cycle.
- R7: `cnt_reload_i` copies the modulo register into the counter at the next edge without an overflow pulse. It wins over a count event in the same cycle.
- R8: With select 01, the counter advances once every 128 `sys_en_i` cycles, counted from a prescaler clear.
- R9: With select 10, the counter advances once every 32768 `sys_en_i` cycles, counted from a prescaler clear.
- R10: With select 11, each falling edge of `ext_pin_i` advances the counter on the third clock edge after the pin changes, even while `sys_en_i` is low. Rising edges do not count.
- R11: `div_clr_i` resets the prescaler to zero at the next edge and suppresses any tap pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_en_i | input | 1 | System clock enable; low in stop mode |
| div_clr_i | input | 1 | Clear prescaler command |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control word: bit 3 run, bits 1:0 source |
| mod_we_i | input | 1 | Modulo register write strobe |
| mod_hi_i | input | 4 | Upper nibble of the modulo value |
| mod_lo_i | input | 4 | Lower nibble of the modulo value |
| cnt_reload_i | input | 1 | Copy modulo register into counter |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| ctrl_o | output | 4 | Control register readback |
| mod_o | output | 8 | Modulo register readback |
| cnt_o | output | 8 | Counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
Register writes, reloads and system-clock counts are visible one edge after the strobe. The overflow pulse appears on the same edge that reloads the counter. Tap counts land on edge 128 or 32768 after the clear edge, and an external falling edge lands on the third edge after the pin moves. The bench drives every input on the falling clock edge and samples on a later falling edge, a counted number of edges after the stimulus. For each latency it checks both the last cycle before the expected change and the cycle of the change.

// File: rtl/modt_pkg.sv
package modt_pkg;
  typedef enum logic [1:0] {
    SRC_SYS    = 2'b00,
    SRC_DIV_LO = 2'b01,
    SRC_DIV_HI = 2'b10,
    SRC_EXT    = 2'b11
  } clk_src_e;

  localparam int CTRL_W  = 4;
  localparam int RUN_BIT = 3;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 4'b1011;
endpackage

// File: rtl/modt_prescaler.sv
module modt_prescaler #(
  parameter int DIV_W  = 15,
  parameter int TAP_LO = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  output logic tick_lo_o,
  output logic tick_hi_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (adv_i) div_q <= div_q + 1'b1;
  end

  // tap fires on the advance that carries out of the selected stages
  assign tick_lo_o = adv_i & ~clr_i & (&div_q[TAP_LO-1:0]);
  assign tick_hi_o = adv_i & ~clr_i & (&div_q);

  // R11
  div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0));
  // R8
  tick_lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_lo_o |=> !tick_lo_o);
endmodule

// File: rtl/modt_edge_sync.sv
module modt_edge_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], pin_i};
      prev_q <= sync_q[SYNC_W-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_W-1];

  // R10
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/modt_counter.sv
module modt_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         reload_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (reload_i) begin
        cnt_q <= mod_i;   // forced reload wins over a count event
      end else if (cnt_en_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= mod_i;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R6
  ovf_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> ($past(cnt_q) == CNT_MAX) && (cnt_q == $past(mod_i)));
  // R7
  cmd_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_q == $past(mod_i)) && !ovf_q);
endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
  import modt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 15,
  parameter int TAP_LO = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_en_i,
  input  logic              div_clr_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              mod_we_i,
  input  logic [CNT_W/2-1:0] mod_hi_i,
  input  logic [CNT_W/2-1:0] mod_lo_i,
  input  logic              cnt_reload_i,
  input  logic              ext_pin_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  mod_q;
  logic              tick_lo, tick_hi, ext_fall;
  logic              src_ev, cnt_en;
  clk_src_e          src_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mod_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTRL_MASK;
      if (mod_we_i)  mod_q  <= {mod_hi_i, mod_lo_i};
    end
  end

  modt_prescaler #(.DIV_W(DIV_W), .TAP_LO(TAP_LO)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (sys_en_i),
    .clr_i     (div_clr_i),
    .tick_lo_o (tick_lo),
    .tick_hi_o (tick_hi)
  );

  modt_edge_sync #(.SYNC_W(2)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .fall_o (ext_fall)
  );

  assign src_sel = clk_src_e'(ctrl_q[1:0]);

  always_comb begin
    unique case (src_sel)
      SRC_SYS:    src_ev = sys_en_i;
      SRC_DIV_LO: src_ev = tick_lo;
      SRC_DIV_HI: src_ev = tick_hi;
      default:    src_ev = ext_fall;
    endcase
  end

  assign cnt_en = ctrl_q[RUN_BIT] & src_ev;

  modt_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en),
    .reload_i (cnt_reload_i),
    .mod_i    (mod_q),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_o)
  );

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;

  // R5
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[RUN_BIT] && !cnt_reload_i) |=> $stable(cnt_o) && !ovf_o);
  // R4
  sys_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel == SRC_SYS && !sys_en_i && !cnt_reload_i) |=> $stable(cnt_o));
endmodule

// File: tb/tb_modulo_timer.sv
`timescale 1ns/1ps
module tb_modulo_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sys_en_i = 1'b1;
  logic       div_clr_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [3:0] ctrl_wdata_i = '0;
  logic       mod_we_i = 1'b0;
  logic [3:0] mod_hi_i = '0;
  logic [3:0] mod_lo_i = '0;
  logic       cnt_reload_i = 1'b0;
  logic       ext_pin_i = 1'b1;
  logic [3:0] ctrl_o;
  logic [7:0] mod_o;
  logic [7:0] cnt_o;
  logic       ovf_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modulo_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .sys_en_i(sys_en_i), .div_clr_i(div_clr_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .mod_we_i(mod_we_i),
    .mod_hi_i(mod_hi_i), .mod_lo_i(mod_lo_i), .cnt_reload_i(cnt_reload_i),
    .ext_pin_i(ext_pin_i), .ctrl_o(ctrl_o), .mod_o(mod_o), .cnt_o(cnt_o),
    .ovf_o(ovf_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v, input bit clr);
    ctrl_wdata_i = v; ctrl_we_i = 1'b1; div_clr_i = clr;
    tick(1);
    ctrl_we_i = 1'b0; div_clr_i = 1'b0;
  endtask

  task automatic wr_mod(input logic [7:0] v);
    mod_hi_i = v[7:4]; mod_lo_i = v[3:0]; mod_we_i = 1'b1;
    tick(1);
    mod_we_i = 1'b0;
  endtask

  task automatic do_reload();
    cnt_reload_i = 1'b1;
    tick(1);
    cnt_reload_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cnt", cnt_o, 8'h00);
    check("R1 mod", mod_o, 8'h00);
    check("R1 ctrl", {4'h0, ctrl_o}, 8'h00);
    check("R1 ovf", {7'h0, ovf_o}, 8'h00);
  endtask

  task automatic t_regs();
    wr_mod(8'hA5);
    check("R2 mod nibbles", mod_o, 8'hA5);
    wr_ctrl(4'b0110, 1'b0);
    check("R3 bit2 dropped", {4'h0, ctrl_o}, 8'h02);
    tick(5);
    check("R5 stopped hold", cnt_o, 8'h00);
  endtask

  task automatic t_reload();
    do_reload();
    check("R7 reload value", cnt_o, 8'hA5);
    check("R7 no ovf", {7'h0, ovf_o}, 8'h00);
  endtask

  task automatic t_sys();
    wr_ctrl(4'b1000, 1'b0);
    check("R4 first edge", cnt_o, 8'hA5);
    tick(3);
    check("R4 sys count", cnt_o, 8'hA8);
    sys_en_i = 1'b0;
    tick(4);
    check("R4 sys gated", cnt_o, 8'hA8);
    sys_en_i = 1'b1;
  endtask

  task automatic t_ovf();
    wr_mod(8'hFD);
    do_reload();
    check("R7 reload beats count", cnt_o, 8'hFD);
    tick(1); check("R6 pre FE", cnt_o, 8'hFE);
    tick(1); check("R6 pre FF", cnt_o, 8'hFF);
    check("R6 no early ovf", {7'h0, ovf_o}, 8'h00);
    tick(1); check("R6 reload on ovf", cnt_o, 8'hFD);
    check("R6 ovf pulse", {7'h0, ovf_o}, 8'h01);
    tick(1); check("R6 after ovf", cnt_o, 8'hFE);
    check("R6 pulse one cycle", {7'h0, ovf_o}, 8'h00);
    wr_ctrl(4'b0000, 1'b0);
    tick(5);
    check("R5 hold after stop", cnt_o, 8'hFF);
  endtask

  task automatic t_div_lo();
    wr_mod(8'h00);
    do_reload();
    wr_ctrl(4'b1001, 1'b1);
    tick(127); check("R8 before tap", cnt_o, 8'h00);
    tick(1);   check("R8 tap 128", cnt_o, 8'h01);
    tick(100);
    div_clr_i = 1'b1; tick(1); div_clr_i = 1'b0;
    tick(127); check("R11 clear restarts", cnt_o, 8'h01);
    tick(1);   check("R11 tap after clear", cnt_o, 8'h02);
  endtask

  task automatic t_div_hi();
    wr_ctrl(4'b1010, 1'b1);
    tick(32767); check("R9 before tap", cnt_o, 8'h02);
    tick(1);     check("R9 tap 32768", cnt_o, 8'h03);
  endtask

  task automatic t_ext();
    wr_ctrl(4'b1011, 1'b0);
    sys_en_i = 1'b0;
    ext_pin_i = 1'b0;
    tick(2); check("R10 sync latency", cnt_o, 8'h03);
    tick(1); check("R10 fall counted", cnt_o, 8'h04);
    ext_pin_i = 1'b1;
    tick(6); check("R10 rise ignored", cnt_o, 8'h04);
    ext_pin_i = 1'b0;
    tick(3); check("R10 second fall", cnt_o, 8'h05);
    sys_en_i = 1'b1;
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_reload();
    t_sys();
    t_ovf();
    t_div_lo();
    t_div_hi();
    t_ext();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule